// File: doc/BRIEF.md
# Field-Assisted Row Write Sequencer

This block runs one complete write of a single row in a magnetic memory array. In this array a shared field line runs along each row and destabilises every cell on it. Each write request carries a row address and a full row of data. The sequencer switches on the row's wordline and the shared field current first. After a programmable lead time it enables the per-column spin currents, whose directions encode the data. It holds them for a programmable pulse length and then drops every enable for one cycle. It then reads the row back.

The read-back is compared with the requested data across the whole row. Any mismatch causes the whole row to be written again, up to a programmable retry limit. Every column is driven on every attempt, because the field disturbs all cells of the row and no bit can be left out.

When the write succeeds, or when the retry limit is used up, the block returns to ready. It reports the number of retries used and whether the limit was exhausted. The analog drivers, the sense path and the cells sit outside the block.

Top module: `frow_write_seq`

## Requirements
- R1: `fld_en_o` and `wl_en_o` are high for exactly `LEAD_CYC` cycles before `spin_en_o` rises, and both stay high for every cycle in which `spin_en_o` is high.
- R2: Each spin-current pulse (`spin_en_o` high) lasts exactly `PULSE_CYC` consecutive cycles.
- R3: While `spin_en_o` is high, `col_dir_o[i]` equals bit i of the requested data for every column (1 = reverse current, writes a 1; 0 = forward current, writes a 0). Every accepted request produces at least one pulse, even when the row already holds the same data.
- R4: `fld_en_o` and `spin_en_o` are both low in the cycle before `rd_en_o` rises, and they stay low while `rd_en_o` is high.
- R5: After every pulse, a verify read of the same row is issued (`rd_en_o` held until `rd_valid_i`). A mismatch in any bit of `rd_data_i` starts another full write of that row.
- R6: At most `RETRY_MAX` retries follow the first write. If the last verify still mismatches, `err_o` is set to 1 and `req_ready_o` still returns high.
- R7: Once ready returns, `retry_cnt_o` holds the number of retries used by the last write and `err_o` shows whether the limit was exhausted. Both are cleared when a new request is accepted.
- R8: `req_ready_o` drops in the cycle after a request is accepted and stays low until the sequence completes. A request held valid while the block is busy is accepted later and is not lost.
- R9: After reset, `req_ready_o` is 1 and all enables, `err_o` and `retry_cnt_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request valid |
| req_ready_o | output | 1 | Sequencer idle, request taken when valid |
| req_addr_i | input | ADDR_W | Row address of the request |
| req_data_i | input | ROW_W | Data for the whole row |
| row_addr_o | output | ADDR_W | Selected row |
| wl_en_o | output | 1 | Wordline enable |
| fld_en_o | output | 1 | Shared row field-current enable |
| spin_en_o | output | 1 | Per-column spin-current enable |
| col_dir_o | output | ROW_W | Column current direction, 1 = reverse |
| rd_en_o | output | 1 | Verify read strobe |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | ROW_W | Read-back row data |
| err_o | output | 1 | Last write exhausted the retry limit |
| retry_cnt_o | output | RETRY_W | Retries used by the last write |

## Verification
The bench builds the block with a 32-column row, 8 rows, a field lead of 2 cycles, a 3-cycle pulse and a retry limit of 2. The 2-cycle lead separates a lead counted right from one that is off by one. The small retry limit lets forced failures reach both the last allowed retry and exhaustion with the error flag. The behavioural array flips one bit on each failing write, which makes the verify compare catch it. The bench then runs directed and randomly mixed failure counts.

// File: rtl/frow_pkg.sv
package frow_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIELD,
    ST_PULSE,
    ST_RELEASE,
    ST_VERIFY,
    ST_COMPARE,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/frow_phase_timer.sv
module frow_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R2: phase length comes from a steady countdown
  a_r2_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/frow_row_cmp.sv
module frow_row_cmp #(
  parameter int ROW_W = 128,
  parameter int SEG_W = 32
) (
  input  logic [ROW_W-1:0] want_i,
  input  logic [ROW_W-1:0] got_i,
  output logic             miss_o
);
  localparam int NSEG = (ROW_W + SEG_W - 1) / SEG_W;

  logic [ROW_W-1:0] diff;
  logic [NSEG-1:0]  seg_miss;

  assign diff = want_i ^ got_i;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam int LO = s * SEG_W;
    localparam int HI = ((LO + SEG_W) < ROW_W ? (LO + SEG_W) : ROW_W) - 1;
    assign seg_miss[s] = |diff[HI:LO];
  end

  assign miss_o = |seg_miss;
endmodule

// File: rtl/frow_col_drv.sv
module frow_col_drv #(
  parameter int ROW_W = 128
) (
  input  logic             fire_i,
  input  logic [ROW_W-1:0] data_i,
  output logic [ROW_W-1:0] dir_o
);
  // one direction driver per column; 1 = reverse current
  for (genvar c = 0; c < ROW_W; c++) begin : g_col
    assign dir_o[c] = fire_i & data_i[c];
  end
endmodule

// File: rtl/frow_write_seq.sv
module frow_write_seq
  import frow_pkg::*;
#(
  parameter int ROW_W     = 128,
  parameter int ADDR_W    = 8,
  parameter int LEAD_CYC  = 1,
  parameter int PULSE_CYC = 3,
  parameter int RETRY_MAX = 4,
  localparam int RETRY_W  = (RETRY_MAX < 1) ? 1 : $clog2(RETRY_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [ROW_W-1:0]   req_data_i,
  output logic [ADDR_W-1:0]  row_addr_o,
  output logic               wl_en_o,
  output logic               fld_en_o,
  output logic               spin_en_o,
  output logic [ROW_W-1:0]   col_dir_o,
  output logic               rd_en_o,
  input  logic               rd_valid_i,
  input  logic [ROW_W-1:0]   rd_data_i,
  output logic               err_o,
  output logic [RETRY_W-1:0] retry_cnt_o
);
  localparam int TMAX  = (LEAD_CYC > PULSE_CYC) ? LEAD_CYC : PULSE_CYC;
  localparam int TMR_W = $clog2(TMAX + 1);
  localparam logic [TMR_W-1:0]   LEAD_LD  = TMR_W'(LEAD_CYC - 1);
  localparam logic [TMR_W-1:0]   PULSE_LD = TMR_W'(PULSE_CYC - 1);
  localparam logic [RETRY_W-1:0] RMAX     = RETRY_W'(RETRY_MAX);

  seq_state_e         state_q, state_d;
  logic [ADDR_W-1:0]  addr_q;
  logic [ROW_W-1:0]   data_q;
  logic [RETRY_W-1:0] retry_q;
  logic               err_q, miss_q;
  logic               tmr_load, tmr_done, cmp_miss;
  logic [TMR_W-1:0]   tmr_val;
  logic               accept;

  assign accept = (state_q == ST_IDLE) && req_valid_i;

  frow_phase_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .done_o(tmr_done)
  );

  frow_row_cmp #(.ROW_W(ROW_W)) u_cmp (
    .want_i(data_q), .got_i(rd_data_i), .miss_o(cmp_miss)
  );

  frow_col_drv #(.ROW_W(ROW_W)) u_drv (
    .fire_i(spin_en_o), .data_i(data_q), .dir_o(col_dir_o)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = LEAD_LD;
    unique case (state_q)
      ST_IDLE:    if (req_valid_i) begin state_d = ST_FIELD; tmr_load = 1'b1; end
      ST_FIELD:   if (tmr_done) begin
                    state_d = ST_PULSE; tmr_load = 1'b1; tmr_val = PULSE_LD;
                  end
      ST_PULSE:   if (tmr_done) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_VERIFY;
      ST_VERIFY:  if (rd_valid_i) state_d = ST_COMPARE;
      ST_COMPARE: if (!miss_q || retry_q == RMAX) state_d = ST_DONE;
                  else begin state_d = ST_FIELD; tmr_load = 1'b1; end
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      retry_q <= '0;
      err_q   <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= req_addr_i;
        data_q  <= req_data_i;
        retry_q <= '0;
        err_q   <= 1'b0;
      end
      if (state_q == ST_VERIFY && rd_valid_i) miss_q <= cmp_miss;
      if (state_q == ST_COMPARE && miss_q) begin
        if (retry_q == RMAX) err_q <= 1'b1;
        else                 retry_q <= retry_q + 1'b1;
      end
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign row_addr_o  = addr_q;
  assign fld_en_o    = (state_q == ST_FIELD) || (state_q == ST_PULSE);
  assign spin_en_o   = (state_q == ST_PULSE);
  assign wl_en_o     = fld_en_o || (state_q == ST_VERIFY);
  assign rd_en_o     = (state_q == ST_VERIFY);
  assign err_o       = err_q;
  assign retry_cnt_o = retry_q;

  // R1: field already on in the cycle before the spin currents start
  a_r1_field_leads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spin_en_o) |-> $past(fld_en_o));
  // R1: field only drops right after a pulse
  a_r1_field_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fld_en_o) |-> $past(spin_en_o));
  // R4: one dead cycle between drive and read
  a_r4_release_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_en_o) |-> $past(!fld_en_o && !spin_en_o));
  // R5: verify read follows every pulse
  a_r5_verify_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spin_en_o) |=> rd_en_o);
  // R6: retry counter bounded
  a_r6_retry_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_cnt_o <= RMAX);
  // R8: ready drops once a request is taken
  a_r8_ready_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
endmodule

// File: tb/frow_write_seq_tb.sv
module frow_write_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 32, ADDR_W = 3, LEAD = 2, PULSE = 3, RMAX = 2;
  localparam int RW = $clog2(RMAX + 1);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0, row_addr;
  logic [ROW_W-1:0]  req_data = '0, col_dir, rd_data = '0;
  logic wl_en, fld_en, spin_en, rd_en, rd_valid = 0, err;
  logic [RW-1:0] retry_cnt;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frow_write_seq #(.ROW_W(ROW_W), .ADDR_W(ADDR_W), .LEAD_CYC(LEAD),
                   .PULSE_CYC(PULSE), .RETRY_MAX(RMAX)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_data_i(req_data), .row_addr_o(row_addr),
    .wl_en_o(wl_en), .fld_en_o(fld_en), .spin_en_o(spin_en), .col_dir_o(col_dir),
    .rd_en_o(rd_en), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .err_o(err), .retry_cnt_o(retry_cnt));

  // behavioural array + monitor, all at the falling edge
  logic [ROW_W-1:0] mem [2**ADDR_W];
  logic [ROW_W-1:0] cap;
  int fail_left = 0, writes = 0, reads = 0, bad_timing = 0, bad_seq = 0, bad_dir = 0;
  int lead_run = 0, pulse_run = 0;
  bit spin_prev = 0, rd_prev = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (spin_en && (!fld_en || !wl_en)) bad_seq++;
      if (rd_en && (fld_en || spin_en)) bad_seq++;
      if (rd_en && !rd_prev && spin_prev) bad_seq++;
      if (fld_en && !spin_en) lead_run++;
      else if (!fld_en) lead_run = 0;
      if (spin_en) begin
        if (!spin_prev && lead_run != LEAD) bad_timing++;
        pulse_run++;
        cap = col_dir;
        if (col_dir != req_data_hold) bad_dir++;
      end else if (spin_prev) begin
        if (pulse_run != PULSE) bad_timing++;
        pulse_run = 0;
        lead_run = 0;
        writes++;
        mem[row_addr] = (fail_left > 0) ? (cap ^ 32'h1) : cap;
        if (fail_left > 0) fail_left--;
      end
      if (rd_en && !rd_prev) reads++;
      if (rd_en && !rd_valid) begin rd_valid = 1; rd_data = mem[row_addr]; end
      else rd_valid = 0;
      spin_prev = spin_en;
      rd_prev = rd_en;
    end
  end

  logic [ROW_W-1:0] req_data_hold = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clr_mon();
    writes = 0; reads = 0; bad_timing = 0; bad_seq = 0; bad_dir = 0;
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic [ADDR_W-1:0] a, input logic [ROW_W-1:0] d);
    bit acc = 0;
    req_addr = a; req_data = d; req_valid = 1;
    while (!acc) begin
      acc = req_ready;
      @(negedge clk);
    end
    req_data_hold = d;
    req_valid = 0;
  endtask

  task automatic wait_done();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [ROW_W-1:0] d,
                          input int fails, input string tag);
    int exp_r = (fails > RMAX) ? RMAX : fails;
    bit exp_e = (fails > RMAX);
    clr_mon();
    fail_left = fails;
    send(a, d);
    chk(req_ready == 0, "R8", {tag, " ready low after accept"}, req_ready, 0);
    wait_done();
    chk(bad_timing == 0, "R1/R2", {tag, " lead/pulse length"}, bad_timing, 0);
    chk(bad_seq == 0, "R4", {tag, " enable ordering"}, bad_seq, 0);
    chk(bad_dir == 0, "R3", {tag, " column directions"}, bad_dir, 0);
    chk(writes == exp_r + 1, "R5", {tag, " write attempts"}, writes, exp_r + 1);
    chk(reads == writes, "R5", {tag, " verify reads"}, reads, writes);
    chk(retry_cnt == RW'(exp_r), "R7", {tag, " retry count"}, retry_cnt, exp_r);
    chk(err == exp_e, "R6", {tag, " error flag"}, err, exp_e);
    if (!exp_e) chk(mem[a] == d, "R3", {tag, " row stored"}, mem[a], d);
    else        chk(mem[a] != d, "R6", {tag, " row left failed"}, mem[a], d ^ 32'h1);
  endtask

  task automatic t_reset();
    chk(req_ready == 1, "R9", "ready after reset", req_ready, 1);
    chk({wl_en, fld_en, spin_en, rd_en} == 4'b0, "R9", "enables after reset",
        {wl_en, fld_en, spin_en, rd_en}, 0);
    chk(err == 0 && retry_cnt == 0, "R9", "status after reset", {err, retry_cnt}, 0);
  endtask

  task automatic t_basic();
    do_write(3'd1, 32'hA5A5_0F0F, 0, "basic");
    do_write(3'd2, 32'hFFFF_FFFF, 0, "ones");
    do_write(3'd3, 32'h0000_0000, 0, "zeros");
  endtask

  task automatic t_repeat_same();
    do_write(3'd1, 32'hA5A5_0F0F, 0, "same data rewrite R3");
    chk(writes == 1, "R3", "pulse issued for unchanged row", writes, 1);
  endtask

  task automatic t_retry();
    do_write(3'd4, 32'h1234_5678, 1, "one retry R5");
    do_write(3'd5, 32'h8765_4321, RMAX, "last retry R6");
  endtask

  task automatic t_exhaust();
    do_write(3'd6, 32'hDEAD_BEEF, RMAX + 1, "exhaust R6");
    do_write(3'd6, 32'hCAFE_F00D, 0, "clear after error R7");
  endtask

  task automatic t_backpressure();
    int stall = 0;
    clr_mon();
    fail_left = 0;
    send(3'd7, 32'h1111_2222);
    req_addr = 3'd0; req_data = 32'h3333_4444; req_valid = 1;
    while (!req_ready) begin stall++; @(negedge clk); end
    chk(stall > LEAD + PULSE, "R8", "busy stall length", stall, LEAD + PULSE + 1);
    chk(writes == 1, "R8", "second request held while busy", writes, 1);
    @(negedge clk);
    req_data_hold = 32'h3333_4444;
    req_valid = 0;
    wait_done();
    chk(mem[7] == 32'h1111_2222, "R8", "first request stored", mem[7], 32'h1111_2222);
    chk(mem[0] == 32'h3333_4444, "R8", "held request stored", mem[0], 32'h3333_4444);
    chk(writes == 2, "R8", "both requests written", writes, 2);
  endtask

  task automatic t_random();
    for (int i = 0; i < 12; i++) begin
      int f = $urandom_range(0, RMAX + 1);
      do_write(ADDR_W'($urandom_range(0, 7)), $urandom, f, "random R5 R6");
    end
  endtask

  initial begin
    for (int r = 0; r < 2**ADDR_W; r++) mem[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_repeat_same();
    t_retry();
    t_exhaust();
    t_backpressure();
    t_random();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule